// File: doc/BRIEF.md
# Clock frequency meter

This block measures the rate of one on-chip clock against a fixed reference clock (nominally 26 MHz). The clocks to be measured arrive on three separate source groups. A register port picks the group and a 6-bit index inside that group. The chosen clock passes through a programmable divider, and its divided edges are counted while an open window lasts a fixed number of reference cycles (1024 by default). The 16-bit result stays in a count register. Software converts it to kHz as count × 26000 / 1024 × (divider field + 1).

To start a measurement, software first sets the enable bit on its own, then writes enable and start together. It then polls the start bit, which reads as busy until the count is valid. Writing zero to the control word stops the meter at any time. The window level crosses into the measured clock's domain through a synchronizer. The result comes back through a toggle handshake, so the reference side never samples a counter that is still changing. When the measured clock is stopped, a bounded wait after the window closes makes the result zero.

Top module: `clk_freq_meter`

## Requirements
- R1: After reset, all four words (control at address 0, select at 1, configuration at 2, count at 3) read zero and the meter is idle.
- R2: Control bit 12 is the enable and reads back as written. A write with bits 12 and 4 both set starts a measurement only if enable was already set before that write. Otherwise the write only sets enable.
- R3: Control bit 4 reads 1 from the cycle after an accepted start until the new count is loaded, and then reads 0. A start write while busy does not restart the measurement.
- R4: A control write with bit 12 clear clears enable and busy by the next cycle and leaves the count register unchanged.
- R5: The window lasts WIN_CYC reference cycles. With divider 0, the count equals the number of measured-clock cycles inside the window, within ±1.
- R6: Select bits 1:0 pick the group: 1 selects A, 0 selects B, 2 selects C, and 3 selects no clock. The index fields are bits 13:8 (A), 21:16 (B) and 29:24 (C), and only the chosen group's field is used. Index i picks input bit i-1. Index 0, or an index above SRC_N, picks no clock. The select word reads back as written.
- R7: Configuration bits 31:24 hold the divider field d. The count is floor(window cycles / (d+1)), within ±1.
- R8: While the meter is idle, the count register holds its value.
- R9: With a stopped clock the count is 0, and busy clears within ARM_CYC + WIN_CYC + TMO_CYC + 8 cycles of the start.
- R10: A count that would exceed 16 bits reads 0xFFFF.
- R11: Writes to the select or configuration word while busy do not change the measurement in progress. They take effect at the next start and read back at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Word address (0 control, 1 select, 2 configuration, 3 count) |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data of the addressed word, combinational |
| grp_a_clk_i | input | SRC_N | Group A clock sources |
| grp_b_clk_i | input | SRC_N | Group B clock sources |
| grp_c_clk_i | input | SRC_N | Group C clock sources |

## Verification
Two functions can fall in the same reference cycle: a select or divider write, and the return of a finished result that clears busy. To make them meet, the bench issues select and configuration writes to stray settings on alternate cycles through a whole measurement, so that one write can land on the completion edge. The run passes only if the loaded count matches the settings latched at start and the select word reads back the last value written. The same cycle-level model also judges each abort against a running window, and the refusal of a start written while the meter is disabled.

// File: rtl/fm_pkg.sv
package fm_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ARM, ST_RUN, ST_WAIT} fm_state_e;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_SEL  = 2'd1;
  localparam logic [1:0] ADDR_CFG  = 2'd2;
  localparam logic [1:0] ADDR_CNT  = 2'd3;

  localparam int EN_BIT   = 12;
  localparam int GO_BIT   = 4;
  localparam int IDXA_LSB = 8;
  localparam int IDXB_LSB = 16;
  localparam int IDXC_LSB = 24;
  localparam int DIV_LSB  = 24;

  localparam logic [1:0] GRP_B = 2'd0;
  localparam logic [1:0] GRP_A = 2'd1;
  localparam logic [1:0] GRP_C = 2'd2;
endpackage

// File: rtl/fm_regs.sv
module fm_regs
  import fm_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int DIV_W = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [1:0]       addr_i,
  input  logic [31:0]      wdata_i,
  input  logic             busy_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [31:0]      rdata_o,
  output logic             en_o,
  output logic             start_o,
  output logic             abort_o,
  output logic [1:0]       act_grp_o,
  output logic [IDX_W-1:0] act_idx_o,
  output logic [DIV_W-1:0] act_div_o
);
  logic             en_q;
  logic [1:0]       grp_q;
  logic [IDX_W-1:0] idx_a_q, idx_b_q, idx_c_q, idx_pick;
  logic [DIV_W-1:0] div_q;
  logic             ctrl_wr;
  logic             unused_wdata;

  assign unused_wdata = ^wdata_i;
  assign ctrl_wr = wr_i && (addr_i == ADDR_CTRL);
  // start only counts when enable was set by an earlier write
  assign start_o = ctrl_wr && wdata_i[EN_BIT] && wdata_i[GO_BIT] && en_q && !busy_i;
  assign abort_o = ctrl_wr && !wdata_i[EN_BIT];
  assign en_o    = en_q;

  always_comb begin
    case (grp_q)
      GRP_A:   idx_pick = idx_a_q;
      GRP_B:   idx_pick = idx_b_q;
      GRP_C:   idx_pick = idx_c_q;
      default: idx_pick = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q      <= 1'b0;
      grp_q     <= '0;
      idx_a_q   <= '0;
      idx_b_q   <= '0;
      idx_c_q   <= '0;
      div_q     <= '0;
      act_grp_o <= '0;
      act_idx_o <= '0;
      act_div_o <= '0;
    end else begin
      if (wr_i) begin
        case (addr_i)
          ADDR_CTRL: en_q <= wdata_i[EN_BIT];
          ADDR_SEL: begin
            grp_q   <= wdata_i[1:0];
            idx_a_q <= wdata_i[IDXA_LSB +: IDX_W];
            idx_b_q <= wdata_i[IDXB_LSB +: IDX_W];
            idx_c_q <= wdata_i[IDXC_LSB +: IDX_W];
          end
          ADDR_CFG: div_q <= wdata_i[DIV_LSB +: DIV_W];
          default: ;
        endcase
      end
      if (start_o) begin
        act_grp_o <= grp_q;
        act_idx_o <= idx_pick;
        act_div_o <= div_q;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_CTRL: begin
        rdata_o[EN_BIT] = en_q;
        rdata_o[GO_BIT] = busy_i;
      end
      ADDR_SEL: begin
        rdata_o[1:0]                 = grp_q;
        rdata_o[IDXA_LSB +: IDX_W]   = idx_a_q;
        rdata_o[IDXB_LSB +: IDX_W]   = idx_b_q;
        rdata_o[IDXC_LSB +: IDX_W]   = idx_c_q;
      end
      ADDR_CFG: rdata_o[DIV_LSB +: DIV_W] = div_q;
      default:  rdata_o[CNT_W-1:0] = cnt_i;
    endcase
  end
endmodule

// File: rtl/fm_clk_sel.sv
module fm_clk_sel
  import fm_pkg::*;
#(
  parameter int SRC_N = 4,
  parameter int IDX_W = 6
) (
  input  logic [1:0]       grp_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [SRC_N-1:0] a_i,
  input  logic [SRC_N-1:0] b_i,
  input  logic [SRC_N-1:0] c_i,
  output logic             clk_o
);
  logic [SRC_N-1:0] row;

  always_comb begin
    case (grp_i)
      GRP_A:   row = a_i;
      GRP_B:   row = b_i;
      GRP_C:   row = c_i;
      default: row = '0;
    endcase
    clk_o = 1'b0;
    // index 0 and out-of-range indices leave the output parked low
    for (int i = 0; i < SRC_N; i++)
      if (idx_i == IDX_W'(i + 1)) clk_o = row[i];
  end
endmodule

// File: rtl/fm_tgt_count.sv
module fm_tgt_count #(
  parameter int CNT_W = 16,
  parameter int DIV_W = 8
) (
  input  logic             tclk_i,
  input  logic             rst_ni,
  input  logic             win_i,
  input  logic [DIV_W-1:0] div_i,
  output logic [CNT_W-1:0] hold_o,
  output logic             done_tgl_o
);
  logic [2:0]       win_sync;
  logic [DIV_W-1:0] pre_q, pre_base;
  logic [CNT_W-1:0] cnt_q, cnt_base;
  logic             win_open, win_close;

  assign win_open  =  win_sync[1] & ~win_sync[2];
  assign win_close = ~win_sync[1] &  win_sync[2];
  assign pre_base  = win_open ? '0 : pre_q;
  assign cnt_base  = win_open ? '0 : cnt_q;

  always_ff @(posedge tclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_sync   <= '0;
      pre_q      <= '0;
      cnt_q      <= '0;
      hold_o     <= '0;
      done_tgl_o <= 1'b0;
    end else begin
      win_sync <= {win_sync[1:0], win_i};
      if (win_sync[1]) begin
        if (pre_base == div_i) begin
          pre_q <= '0;
          cnt_q <= (cnt_base == '1) ? cnt_base : cnt_base + 1'b1;
        end else begin
          pre_q <= pre_base + 1'b1;
          cnt_q <= cnt_base;
        end
      end
      if (win_close) begin
        hold_o     <= cnt_q;
        done_tgl_o <= ~done_tgl_o;
      end
    end
  end
endmodule

// File: rtl/fm_window.sv
module fm_window
  import fm_pkg::*;
#(
  parameter int WIN_CYC = 1024,
  parameter int ARM_CYC = 8,
  parameter int TMO_CYC = 64,
  parameter int CNT_W   = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             abort_i,
  input  logic             done_tgl_i,
  input  logic [CNT_W-1:0] hold_i,
  output logic             win_o,
  output logic             busy_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam int MAX_AT  = (ARM_CYC > TMO_CYC) ? ARM_CYC : TMO_CYC;
  localparam int TMR_MAX = (WIN_CYC > MAX_AT) ? WIN_CYC : MAX_AT;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);

  fm_state_e        state_q;
  logic [TMR_W-1:0] tmr_q;
  logic [2:0]       done_sync;
  logic             done_edge;

  assign done_edge = done_sync[2] ^ done_sync[1];
  assign win_o     = (state_q == ST_RUN);
  assign busy_o    = (state_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_sync <= '0;
      state_q   <= ST_IDLE;
      tmr_q     <= '0;
      cnt_o     <= '0;
    end else begin
      done_sync <= {done_sync[1:0], done_tgl_i};
      if (abort_i) begin
        state_q <= ST_IDLE;
        tmr_q   <= '0;
      end else begin
        case (state_q)
          ST_IDLE: if (start_i) begin
            state_q <= ST_ARM;
            tmr_q   <= '0;
          end
          // quiet gap so the measured side sees the window low before it opens
          ST_ARM: if (tmr_q == TMR_W'(ARM_CYC - 1)) begin
            state_q <= ST_RUN;
            tmr_q   <= '0;
          end else tmr_q <= tmr_q + 1'b1;
          ST_RUN: if (tmr_q == TMR_W'(WIN_CYC - 1)) begin
            state_q <= ST_WAIT;
            tmr_q   <= '0;
          end else tmr_q <= tmr_q + 1'b1;
          default: begin
            if (done_edge) begin
              cnt_o   <= hold_i;
              state_q <= ST_IDLE;
            end else if (tmr_q == TMR_W'(TMO_CYC - 1)) begin
              cnt_o   <= '0;
              state_q <= ST_IDLE;
            end else tmr_q <= tmr_q + 1'b1;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/clk_freq_meter.sv
module clk_freq_meter #(
  parameter int SRC_N   = 4,
  parameter int IDX_W   = 6,
  parameter int DIV_W   = 8,
  parameter int CNT_W   = 16,
  parameter int WIN_CYC = 1024,
  parameter int ARM_CYC = 8,
  parameter int TMO_CYC = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [1:0]       addr_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o,
  input  logic [SRC_N-1:0] grp_a_clk_i,
  input  logic [SRC_N-1:0] grp_b_clk_i,
  input  logic [SRC_N-1:0] grp_c_clk_i
);
  logic             en, busy, win, start, abort;
  logic             tclk, done_tgl;
  logic [1:0]       act_grp;
  logic [IDX_W-1:0] act_idx;
  logic [DIV_W-1:0] act_div;
  logic [CNT_W-1:0] cnt_q, hold;

  fm_regs #(.IDX_W(IDX_W), .DIV_W(DIV_W), .CNT_W(CNT_W)) u_regs (
    .clk_i, .rst_ni, .wr_i, .addr_i, .wdata_i,
    .busy_i(busy), .cnt_i(cnt_q), .rdata_o,
    .en_o(en), .start_o(start), .abort_o(abort),
    .act_grp_o(act_grp), .act_idx_o(act_idx), .act_div_o(act_div)
  );

  fm_clk_sel #(.SRC_N(SRC_N), .IDX_W(IDX_W)) u_sel (
    .grp_i(act_grp), .idx_i(act_idx),
    .a_i(grp_a_clk_i), .b_i(grp_b_clk_i), .c_i(grp_c_clk_i),
    .clk_o(tclk)
  );

  fm_tgt_count #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_tgt (
    .tclk_i(tclk), .rst_ni, .win_i(win), .div_i(act_div),
    .hold_o(hold), .done_tgl_o(done_tgl)
  );

  fm_window #(.WIN_CYC(WIN_CYC), .ARM_CYC(ARM_CYC), .TMO_CYC(TMO_CYC), .CNT_W(CNT_W)) u_win (
    .clk_i, .rst_ni, .start_i(start), .abort_i(abort),
    .done_tgl_i(done_tgl), .hold_i(hold),
    .win_o(win), .busy_o(busy), .cnt_o(cnt_q)
  );
endmodule

// File: rtl/fm_chk.sv
module fm_chk
  import fm_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int DIV_W = 8,
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_i,
  input logic [1:0]       addr_i,
  input logic [31:0]      wdata_i,
  input logic             en,
  input logic             busy,
  input logic             win,
  input logic [CNT_W-1:0] cnt_q,
  input logic [1:0]       act_grp,
  input logic [IDX_W-1:0] act_idx,
  input logic [DIV_W-1:0] act_div
);
  // R3
  busy_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(wr_i && addr_i == ADDR_CTRL && wdata_i[EN_BIT] && wdata_i[GO_BIT] && en));

  // R4
  abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == ADDR_CTRL && !wdata_i[EN_BIT]) |=> (!busy && !en));

  // R8
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && !$past(busy)) |-> $stable(cnt_q));

  // R5
  win_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win |-> busy);

  // R11
  settings_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && $past(busy)) |-> ($stable(act_div) && $stable(act_idx) && $stable(act_grp)));
endmodule

bind clk_freq_meter fm_chk #(.IDX_W(IDX_W), .DIV_W(DIV_W), .CNT_W(CNT_W)) u_fm_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .addr_i(addr_i), .wdata_i(wdata_i),
  .en(en), .busy(busy), .win(win), .cnt_q(cnt_q),
  .act_grp(act_grp), .act_idx(act_idx), .act_div(act_div)
);

// File: tb/clk_freq_meter_test.sv
`timescale 1ns/1ps
module clk_freq_meter_test;
  localparam int ARM = 8;
  localparam int WIN = 1024;
  localparam int TMO = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  ca, cb, cc;
  logic        fast_on = 1'b0;

  int checks = 0;
  int fails  = 0;

  // cycle-level model state
  bit          m_en = 0;
  bit          m_busy = 0;
  int          m_cyc = 0;
  bit          m_cnt_valid = 0;
  logic [15:0] m_cnt = '0;

  always #2 clk = ~clk;

  initial begin
    ca = '0; cb = '0; cc = '0;
  end
  always #0.5 ca[0] = ~ca[0];
  always #2   ca[3] = ~ca[3];
  always #1   cb[0] = ~cb[0];
  always #4   cc[0] = ~cc[0];
  initial forever begin
    wait (fast_on);
    #0.031 ca[2] = ~ca[2];
  end

  clk_freq_meter #(.SRC_N(4), .WIN_CYC(WIN), .ARM_CYC(ARM), .TMO_CYC(TMO)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .grp_a_clk_i(ca), .grp_b_clk_i(cb), .grp_c_clk_i(cc)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // model compared every reference cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (m_busy) m_cyc++;
      if (!wr && addr == 2'd0) begin
        chk(rdata[12] == m_en, "R2 enable readback", rdata[12], m_en);
        if (m_busy) begin
          if (m_cyc <= ARM + WIN) chk(rdata[4] == 1'b1, "R3 busy held", rdata[4], 1);
          else if (!rdata[4]) begin
            chk(m_cyc <= ARM + WIN + TMO + 8, "R9 completion bound", m_cyc, ARM + WIN + TMO + 8);
            m_busy = 0;
          end
        end else chk(rdata[4] == 1'b0, "R3 idle busy", rdata[4], 0);
      end
      if (m_busy && m_cyc > ARM + WIN + TMO + 8) begin
        chk(1'b0, "R9 busy stuck", m_cyc, ARM + WIN + TMO + 8);
        m_busy = 0;
      end
      if (!wr && addr == 2'd3 && !m_busy && m_cnt_valid)
        chk(rdata[15:0] == m_cnt, "R8 count held", rdata[15:0], m_cnt);
      // apply the write that the next edge consumes
      if (wr && addr == 2'd0) begin
        if (!wdata[12]) begin
          m_en = 0;
          m_busy = 0;
        end else begin
          if (wdata[4] && m_en && !m_busy) begin
            m_busy = 1;
            m_cyc = 0;
          end
          m_en = 1;
        end
      end
    end
  end

  task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    wr = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr = 1'b0; addr = 2'd0; wdata = '0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    addr = a;
    @(negedge clk);
    d = rdata;
    #1 addr = 2'd0;
  endtask

  task automatic wait_idle();
    while (m_busy) @(negedge clk);
  endtask

  task automatic measure(input logic [31:0] selw, input logic [31:0] cfgw,
                         input int exp, input int tol, input string req);
    logic [31:0] d;
    int diff;
    m_cnt_valid = 0;
    reg_wr(2'd2, cfgw);
    reg_wr(2'd1, selw);
    reg_wr(2'd0, 32'h0000_1000);
    reg_wr(2'd0, 32'h0000_1010);
    wait_idle();
    reg_rd(2'd3, d);
    diff = int'(d[15:0]) - exp;
    if (diff < 0) diff = -diff;
    chk(diff <= tol && d[31:16] == 16'h0, req, d, exp);
    m_cnt = d[15:0];
    m_cnt_valid = 1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "R3 watchdog", 0, 1);
    summary();
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset values
    for (int a = 0; a < 4; a++) begin
      reg_rd(a[1:0], d);
      chk(d == 32'h0, "R1 reset word", d, 0);
    end

    // R2 start refused while enable was clear
    reg_wr(2'd0, 32'h0000_1010);
    repeat (4) @(posedge clk);
    reg_rd(2'd0, d);
    chk(d == 32'h0000_1000, "R2 start without prior enable", d, 32'h1000);

    // R6 select and configuration readback
    reg_wr(2'd1, 32'h3F2A_1501);
    reg_rd(2'd1, d);
    chk(d == 32'h3F2A_1501, "R6 select readback", d, 32'h3F2A1501);
    reg_wr(2'd2, 32'hAB00_0000);
    reg_rd(2'd2, d);
    chk(d == 32'hAB00_0000, "R7 divider readback", d, 32'hAB000000);

    measure(32'h0000_0101, 32'h0000_0000, 4096, 1, "R5 group A idx1 div0");
    measure(32'h0000_0101, 32'h0300_0000, 1024, 1, "R7 div field 3");
    measure(32'h0000_0401, 32'h0700_0000, 128, 1, "R7 div field 7");
    measure(32'h0001_0300, 32'h0000_0000, 2048, 1, "R6 group B idx1");
    measure(32'h0100_0002, 32'h0100_0000, 256, 1, "R6 group C idx1 div1");
    measure(32'h0000_0001, 32'h0000_0000, 0, 0, "R6 index zero");
    measure(32'h0000_0501, 32'h0000_0000, 0, 0, "R6 index above range");
    measure(32'h0101_0103, 32'h0000_0000, 0, 0, "R6 group code 3");
    measure(32'h0000_0201, 32'h0000_0000, 0, 0, "R9 stopped clock");

    fast_on = 1'b1;
    measure(32'h0000_0301, 32'h0000_0000, 65535, 0, "R10 saturation");
    fast_on = 1'b0;

    // R8 held value re-read
    repeat (3) begin
      reg_rd(2'd3, d);
      chk(d[15:0] == m_cnt, "R8 re-read", d[15:0], m_cnt);
    end

    // R11 setting writes during a run, alternating with idle cycles
    for (int k = 0; k < 2; k++) begin
      m_cnt_valid = 0;
      reg_wr(2'd2, 32'h0000_0000);
      reg_wr(2'd1, 32'h0000_0101);
      reg_wr(2'd0, 32'h0000_1010);
      while (m_busy) begin
        reg_wr(2'd1, 32'h0000_0002);
        reg_wr(2'd2, 32'hFF00_0000);
      end
      wait_idle();
      reg_rd(2'd3, d);
      chk(d[15:0] >= 4095 && d[15:0] <= 4097, "R11 count unaffected", d[15:0], 4096);
      m_cnt = d[15:0];
      m_cnt_valid = 1;
      reg_rd(2'd1, d);
      chk(d == 32'h0000_0002, "R11 select readback", d, 2);
    end

    // R3 start while busy is ignored
    reg_wr(2'd1, 32'h0000_0101);
    reg_wr(2'd2, 32'h0000_0000);
    m_cnt_valid = 0;
    reg_wr(2'd0, 32'h0000_1010);
    repeat (50) @(posedge clk);
    reg_wr(2'd0, 32'h0000_1010);
    wait_idle();
    reg_rd(2'd3, d);
    chk(d[15:0] >= 4095 && d[15:0] <= 4097, "R3 restart ignored", d[15:0], 4096);
    m_cnt = d[15:0];
    m_cnt_valid = 1;

    // R4 abort mid-window
    reg_wr(2'd0, 32'h0000_1010);
    repeat (100) @(posedge clk);
    reg_wr(2'd0, 32'h0000_0000);
    reg_rd(2'd0, d);
    chk(d == 32'h0, "R4 abort clears control", d, 0);
    reg_rd(2'd3, d);
    chk(d[15:0] == m_cnt, "R4 count kept", d[15:0], m_cnt);
    reg_wr(2'd0, 32'h0000_1010);
    repeat (3) @(posedge clk);
    reg_rd(2'd0, d);
    chk(d == 32'h0000_1000, "R2 no start after abort", d, 32'h1000);
    measure(32'h0000_0101, 32'h0000_0000, 4096, 1, "R4 restart after abort");

    repeat (5) @(posedge clk);
    summary();
    $finish;
  end
endmodule